// File: doc/BRIEF.md
# Effective Address Generator with Base Auto-Update

This block forms the memory address of a load or store operand from the operand's addressing mode, and in the same step produces the base-register writeback that the post-increment and pre-decrement modes need. The mode, the base and index register values, a 16-bit displacement field, an absolute address and a two-bit step selector are presented together under a valid strobe. One clock later the block presents the effective address, a flag that says whether a memory access is needed, and an optional base-register update made of a value and a write enable.

The step selector picks a power-of-two amount d of 1, 2, 4 or 8. The scaled-index mode uses d to scale the index register. The two auto modes use d as the amount by which the base register moves. Post-increment addresses memory with the old base and writes back the incremented base. Pre-decrement first lowers the base and then uses that lowered value both as the address and as the writeback. Register and immediate operands need no memory access, so they produce zero outputs. All arithmetic wraps modulo 2^32.

Top module: `eag_top`

## Requirements
- R1: While reset is asserted and after it is released, before the first valid input, out_valid, mem_access and wb_en are 0 and ea and wb_value are 0.
- R2: Mode code 2 (register indirect) gives ea = base.
- R3: Mode code 3 (absolute) gives ea = abs_addr.
- R4: Mode code 4 (displacement) gives ea = base + disp, where the 16-bit disp is sign-extended from bit 15 to 32 bits.
- R5: Mode code 5 (indexed) gives ea = base + index.
- R6: Mode code 6 (scaled) gives ea = sign-extended disp + base + index × d.
- R7: Mode code 7 (post-increment) gives ea = base, wb_value = base + d and wb_en = 1.
- R8: Mode code 8 (pre-decrement) gives ea = base − d, wb_value = base − d and wb_en = 1.
- R9: step_sel codes 0, 1, 2 and 3 select d = 1, 2, 4 and 8.
- R10: Mode codes 0 (register), 1 (immediate) and the reserved codes 9 to 15 give mem_access = 0, ea = 0, wb_en = 0 and wb_value = 0.
- R11: mem_access is 1 for mode codes 2 to 8. wb_en is 1 only for codes 7 and 8. wb_value is 0 whenever wb_en is 0.
- R12: All address sums and differences wrap modulo 2^32.
- R13: The outputs reflect the inputs sampled at the previous rising edge on which in_valid was 1. out_valid equals in_valid delayed by one cycle. While in_valid is 0, ea, mem_access, wb_en and wb_value hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Inputs are valid and should be captured |
| mode | input | 4 | Addressing mode code |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| disp | input | 16 | Displacement field, signed |
| abs_addr | input | 32 | Absolute address from the instruction |
| step_sel | input | 2 | Step/scale select, d = 1 << step_sel |
| out_valid | output | 1 | Result registers were loaded on the previous edge |
| ea | output | 32 | Effective address |
| mem_access | output | 1 | Operand needs a memory access |
| wb_en | output | 1 | Base-register write enable |
| wb_value | output | 32 | New base-register value |

## Verification
A wrong mode decode or a wrong step decode shows up at the ports one cycle after the offending input, as a bad address or a bad flag. A result register that fails to hold shows up on the first idle cycle after a valid one. An update ordering that is swapped between the two auto modes shows up as ea differing from wb_value in pre-decrement, or as ea equal to wb_value in post-increment. The bench compares every output on every clock against a behavioural model. It drives random operands, and it also drives directed vectors for the sign-extension, wrap-around and all-steps corners, so each such fault is reported in the cycle where it first appears.

// File: rtl/eag_pkg.sv
package eag_pkg;
  typedef enum logic [3:0] {
    EAM_REG     = 4'd0,
    EAM_IMM     = 4'd1,
    EAM_IND     = 4'd2,
    EAM_ABS     = 4'd3,
    EAM_DISP    = 4'd4,
    EAM_IDX     = 4'd5,
    EAM_SCALED  = 4'd6,
    EAM_POSTINC = 4'd7,
    EAM_PREDEC  = 4'd8
  } eam_e;
endpackage

// File: rtl/eag_scaler.sv
module eag_scaler #(
  parameter int W      = 32,
  parameter int STEP_W = 2
) (
  input  logic [W-1:0]      val,
  input  logic [STEP_W-1:0] sel,
  output logic [W-1:0]      scaled,
  output logic [W-1:0]      step
);
  localparam int NSTEP = 1 << STEP_W;

  logic [W-1:0] shifted [NSTEP];
  logic [W-1:0] pow     [NSTEP];

  for (genvar k = 0; k < NSTEP; k++) begin : g_shift
    assign shifted[k] = val << k;
    assign pow[k]     = W'(1) << k;
  end

  assign scaled = shifted[sel];
  assign step   = pow[sel];
endmodule

// File: rtl/eag_calc.sv
module eag_calc
  import eag_pkg::*;
#(
  parameter int W      = 32,
  parameter int STEP_W = 2
) (
  input  logic [3:0]        mode,
  input  logic [W-1:0]      base,
  input  logic [W-1:0]      index,
  input  logic [W-1:0]      disp_ext,
  input  logic [W-1:0]      abs_addr,
  input  logic [STEP_W-1:0] step_sel,
  output logic [W-1:0]      ea,
  output logic              access,
  output logic              wb_en,
  output logic [W-1:0]      wb_value
);
  logic [W-1:0] idx_scaled;
  logic [W-1:0] step;
  logic [W-1:0] base_dec;

  eag_scaler #(.W(W), .STEP_W(STEP_W)) i_scaler (
    .val    (index),
    .sel    (step_sel),
    .scaled (idx_scaled),
    .step   (step)
  );

  assign base_dec = base - step;

  always_comb begin
    ea       = '0;
    access   = 1'b0;
    wb_en    = 1'b0;
    wb_value = '0;
    case (mode)
      EAM_IND:    begin ea = base;                         access = 1'b1; end
      EAM_ABS:    begin ea = abs_addr;                     access = 1'b1; end
      EAM_DISP:   begin ea = base + disp_ext;              access = 1'b1; end
      EAM_IDX:    begin ea = base + index;                 access = 1'b1; end
      EAM_SCALED: begin ea = disp_ext + base + idx_scaled; access = 1'b1; end
      EAM_POSTINC: begin
        ea       = base;
        access   = 1'b1;
        wb_en    = 1'b1;
        wb_value = base + step;
      end
      EAM_PREDEC: begin
        ea       = base_dec;
        access   = 1'b1;
        wb_en    = 1'b1;
        wb_value = base_dec;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eag_top.sv
module eag_top
  import eag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int STEP_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [3:0]        mode,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] abs_addr,
  input  logic [STEP_W-1:0] step_sel,
  output logic              out_valid,
  output logic [ADDR_W-1:0] ea,
  output logic              mem_access,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_value
);
  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] c_ea, c_wb_value;
  logic              c_access, c_wb_en;

  logic [ADDR_W-1:0] ea_d, wb_value_d;
  logic              access_d, wb_en_d;

  assign disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

  eag_calc #(.W(ADDR_W), .STEP_W(STEP_W)) i_calc (
    .mode     (mode),
    .base     (base),
    .index    (index),
    .disp_ext (disp_ext),
    .abs_addr (abs_addr),
    .step_sel (step_sel),
    .ea       (c_ea),
    .access   (c_access),
    .wb_en    (c_wb_en),
    .wb_value (c_wb_value)
  );

  // next state: load on valid, otherwise hold
  always_comb begin
    ea_d       = ea;
    access_d   = mem_access;
    wb_en_d    = wb_en;
    wb_value_d = wb_value;
    if (in_valid) begin
      ea_d       = c_ea;
      access_d   = c_access;
      wb_en_d    = c_wb_en;
      wb_value_d = c_wb_value;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      ea         <= '0;
      mem_access <= 1'b0;
      wb_en      <= 1'b0;
      wb_value   <= '0;
    end else begin
      out_valid  <= in_valid;
      ea         <= ea_d;
      mem_access <= access_d;
      wb_en      <= wb_en_d;
      wb_value   <= wb_value_d;
    end
  end

  p_valid_delay_r13: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_hold_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(ea) && $stable(wb_value) && $stable(wb_en) && $stable(mem_access)));

  p_wb_implies_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> mem_access);

  p_postinc_old_base_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == EAM_POSTINC) |=> (ea == $past(base) && wb_en && wb_value != ea));

  p_predec_same_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == EAM_PREDEC) |=> (wb_en && ea == wb_value && ea != $past(base)));

  p_no_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (mode == EAM_REG || mode == EAM_IMM)) |=> (!mem_access && !wb_en && ea == '0));

  p_indirect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == EAM_IND) |=> (ea == $past(base) && !wb_en));
endmodule

// File: tb/test_eag_top.sv
module test_eag_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  mode = '0;
  logic [31:0] base = '0, index = '0, abs_addr = '0;
  logic [15:0] disp = '0;
  logic [1:0]  step_sel = '0;
  logic        out_valid, mem_access, wb_en;
  logic [31:0] ea, wb_value;

  int vectors = 0;
  int miscompares = 0;

  logic [31:0] x_ea = '0, x_wb = '0;
  logic        x_acc = 1'b0, x_wen = 1'b0, x_ov = 1'b0;

  always #10 clk = ~clk;

  eag_top i_eag_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
    .base(base), .index(index), .disp(disp), .abs_addr(abs_addr),
    .step_sel(step_sel), .out_valid(out_valid), .ea(ea),
    .mem_access(mem_access), .wb_en(wb_en), .wb_value(wb_value)
  );

  task automatic model(input logic [3:0] m, input logic [31:0] b, input logic [31:0] ix,
                       input logic [15:0] dp, input logic [31:0] ab, input logic [1:0] s);
    longint d, de, r;
    d  = longint'(1) << s;
    de = longint'($signed(dp));
    x_ea = '0; x_wb = '0; x_acc = 1'b0; x_wen = 1'b0;
    case (m)
      4'd2: begin x_ea = b;  x_acc = 1; end
      4'd3: begin x_ea = ab; x_acc = 1; end
      4'd4: begin r = longint'(b) + de; x_ea = r[31:0]; x_acc = 1; end
      4'd5: begin r = longint'(b) + longint'(ix); x_ea = r[31:0]; x_acc = 1; end
      4'd6: begin r = de + longint'(b) + longint'(ix) * d; x_ea = r[31:0]; x_acc = 1; end
      4'd7: begin x_ea = b; r = longint'(b) + d; x_wb = r[31:0]; x_acc = 1; x_wen = 1; end
      4'd8: begin r = longint'(b) - d; x_ea = r[31:0]; x_wb = r[31:0]; x_acc = 1; x_wen = 1; end
      default: ;
    endcase
  endtask

  task automatic compare(input string tag);
    vectors++;
    if (out_valid !== x_ov || ea !== x_ea || mem_access !== x_acc ||
        wb_en !== x_wen || wb_value !== x_wb) begin
      miscompares++;
      $display("FAIL %s: got ov=%0b ea=%h acc=%0b wen=%0b wb=%h exp ov=%0b ea=%h acc=%0b wen=%0b wb=%h",
               tag, out_valid, ea, mem_access, wb_en, wb_value,
               x_ov, x_ea, x_acc, x_wen, x_wb);
    end
  endtask

  task automatic apply(input logic v, input logic [3:0] m, input logic [31:0] b,
                       input logic [31:0] ix, input logic [15:0] dp,
                       input logic [31:0] ab, input logic [1:0] s, input string tag);
    in_valid = v; mode = m; base = b; index = ix; disp = dp; abs_addr = ab; step_sel = s;
    if (v) model(m, b, ix, dp, ab, s);
    x_ov = v;
    @(negedge clk);
    compare(tag);
  endtask

  function automatic string tag_of(input logic [3:0] m);
    case (m)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R10";
    endcase
  endfunction

  initial begin
    #5000000;
    miscompares++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    apply(1, 4'd2, 32'h1000_0040, 32'h5, 16'h0, 32'h0, 2'd0, "R2");
    apply(1, 4'd3, 32'h0, 32'h0, 16'h0, 32'hDEAD_BEE0, 2'd0, "R3");
    apply(1, 4'd4, 32'h0000_1000, 32'h0, 16'hFFF0, 32'h0, 2'd0, "R4");
    apply(1, 4'd4, 32'h0000_1000, 32'h0, 16'h7FFF, 32'h0, 2'd0, "R4");
    apply(1, 4'd5, 32'h0000_2000, 32'h0000_0124, 16'h0, 32'h0, 2'd0, "R5");
    for (int s = 0; s < 4; s++) begin
      apply(1, 4'd6, 32'h0000_8000, 32'h0000_0003, 16'hFFFC, 32'h0, 2'(s), "R9");
      apply(1, 4'd7, 32'h0000_0100, 32'h0, 16'h0, 32'h0, 2'(s), "R9");
      apply(1, 4'd8, 32'h0000_0100, 32'h0, 16'h0, 32'h0, 2'(s), "R9");
    end
    apply(1, 4'd7, 32'hFFFF_FFFC, 32'h0, 16'h0, 32'h0, 2'd3, "R12");
    apply(1, 4'd8, 32'h0000_0002, 32'h0, 16'h0, 32'h0, 2'd2, "R12");
    apply(1, 4'd5, 32'hFFFF_FFFF, 32'h2, 16'h0, 32'h0, 2'd0, "R12");
    apply(1, 4'd4, 32'h0000_0004, 32'h0, 16'h8000, 32'h0, 2'd0, "R12");
    apply(1, 4'd0, 32'h1234_5678, 32'h9, 16'h55, 32'h77, 2'd1, "R10");
    apply(1, 4'd1, 32'h1234_5678, 32'h9, 16'h55, 32'h77, 2'd1, "R10");
    apply(1, 4'd12, 32'h1234_5678, 32'h9, 16'h55, 32'h77, 2'd1, "R10");
    apply(1, 4'd7, 32'h0000_4000, 32'h0, 16'h0, 32'h0, 2'd2, "R11");
    apply(0, 4'd3, 32'hAAAA_AAAA, 32'h1, 16'h1, 32'h5555_5555, 2'd0, "R13");
    apply(0, 4'd0, 32'h0, 32'h0, 16'h0, 32'h0, 2'd0, "R13");

    for (int n = 0; n < 600; n++) begin
      logic [3:0] m;
      logic v;
      m = 4'($urandom_range(0, 15));
      v = ($urandom_range(0, 3) != 0);
      apply(v, m, $urandom, $urandom, 16'($urandom), $urandom, 2'($urandom_range(0, 3)),
            v ? tag_of(m) : "R13");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule